// File: doc/BRIEF.md
# Chainable FIFO Slice with Token-Passing Depth Expansion

This block is one slice of a first-in/first-out store of 9-bit words. Used alone, it behaves as an ordinary FIFO with full, empty and half-full flags and a rewind of the read side. Identical slices can also be wired into a ring to build a deeper FIFO. In that arrangement a write token and a read token travel around the ring. The slice that holds the write token stores incoming words. The slice that holds the read token presents the oldest word on a shared output bus. A slice hands a token on when an access uses its last storage location.

The operating mode is taken at reset from the expansion input. If that input is held low during reset, the slice runs alone. In that mode the dual-purpose input rewinds the read pointer, and the dual-purpose output is the half-full flag. If the input is high during reset, the slice runs as part of a ring. In that mode the dual-purpose input marks the slice that starts out owning both tokens, and the dual-purpose output carries the token pulse. A side-band bit sent with each pulse says whether the pulse hands over the write token or the read token.

All state changes on the rising clock edge. Reset is synchronous and active low. Each access is a one-cycle active-high strobe. The output bus shows the oldest word before the read strobe removes it, so a read needs no extra cycle.

Top module: `xfifo_slice`

## Requirements
- R1: In the first cycle after reset is released, emptyN is 0, fullN is 1 and xoHfN is 1, in either mode.
- R2: The mode is captured while rstN is low. xiN low selects single mode and xiN high selects ring mode. Once reset is released, xiN does not change the mode.
- R3: Words are delivered in the order they were written. A write strobe is ignored while the slice is full, and a read strobe is ignored while the slice is empty.
- R4: fullN is 0 exactly when DEPTH words are held, and emptyN is 0 exactly when no word is held. The two flags are never 0 together.
- R5: In single mode, xoHfN is 0 exactly while more than DEPTH/2 words are held.
- R6: In single mode, flRtN low for one cycle with no access sets the read pointer to location zero and leaves the write pointer unchanged. The word count becomes the write pointer, and the words from location zero are delivered again in order.
- R7: In ring mode, the slice whose flRtN is low during reset owns both tokens. Every other slice owns neither token and ignores wrEn and rdEn.
- R8: In ring mode, an accepted write or read at location DEPTH-1 drives xoHfN low for the next cycle, with xoIsWr 1 for a write and 0 for a read. The slice gives up that token at the same edge.
- R9: In ring mode, a slice that sees xiN low takes the write token if xiIsWr is 1 and the read token otherwise. It can use the token in that same cycle.
- R10: qOut carries the word at the read pointer while the slice owns the read token (always in single mode). Otherwise qOut is high-impedance, so a shared bus has a single driver.
- R11: A ring of slices delivers words written across slice boundaries in their original order on the shared bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Write strobe for one cycle |
| rdEn | input | 1 | Read strobe for one cycle |
| dIn | input | DATA_W | Word to store |
| flRtN | input | 1 | Single mode: rewind, active low. Ring mode: first-slice marker |
| xiN | input | 1 | Expansion input: mode select during reset, token pulse in ring mode |
| xiIsWr | input | 1 | Kind of the incoming token pulse (1 = write token) |
| qOut | output | DATA_W | Oldest word, high-impedance when the slice does not own reading |
| fullN | output | 1 | Full flag, active low |
| emptyN | output | 1 | Empty flag, active low |
| xoHfN | output | 1 | Single mode: half-full flag. Ring mode: token pulse out, active low |
| xoIsWr | output | 1 | Kind of the outgoing token pulse (1 = write token) |

## Verification
If the word count is wrong, the flags show it at the next edge: fullN, emptyN or half-full changes one word too early or too late. If a pointer is wrong, the next word seen on qOut is out of order. If token state is wrong, two slices accept the same write or none does. In ring mode this shows up as a word missing or repeated at a slice boundary, and the mistake appears within the DEPTH accesses that follow. If the token pulse is mistimed, it appears on xoHfN one cycle off, or with the wrong kind bit, right after the access to the last location.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;
  typedef struct packed {
    logic wrFire;
    logic rdFire;
    logic rewind;
    logic qDrive;
  } ctrlStrobes_t;
endpackage

// File: rtl/xfifo_dpath.sv
module xfifo_dpath
  import xfifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      stb,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] head,
  output logic [ADDR_W-1:0] wrPtr,
  output logic              wrLast,
  output logic              rdLast
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] rdPtr;

  assign wrLast = (wrPtr == LAST);
  assign rdLast = (rdPtr == LAST);
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (stb.wrFire) mem[wrPtr] <= dIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (stb.wrFire) wrPtr <= wrLast ? '0 : wrPtr + 1'b1;
      if (stb.rewind) rdPtr <= '0;
      else if (stb.rdFire) rdPtr <= rdLast ? '0 : rdPtr + 1'b1;
    end
  end
endmodule

// File: rtl/xfifo_ctrl.sv
module xfifo_ctrl
  import xfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              flRtN,
  input  logic              xiN,
  input  logic              xiIsWr,
  input  logic [ADDR_W-1:0] wrPtr,
  input  logic              wrLast,
  input  logic              rdLast,
  output ctrlStrobes_t      stb,
  output logic              singleMode,
  output logic              fullN,
  output logic              emptyN,
  output logic              xoHfN,
  output logic              xoIsWr
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

  logic [CNT_W-1:0] wordCnt;
  logic wrTok, rdTok, xoPulse, xoKind;
  logic xiPulse, gainWr, gainRd, ownWr, ownRd, notFull, notEmpty;

  always_comb begin
    xiPulse  = !singleMode && !xiN;
    gainWr   = xiPulse && xiIsWr;
    gainRd   = xiPulse && !xiIsWr;
    ownWr    = singleMode || wrTok || gainWr;
    ownRd    = singleMode || rdTok || gainRd;
    notFull  = (wordCnt != FULL_CNT);
    notEmpty = (wordCnt != '0);
    stb.rewind = singleMode && !flRtN;
    stb.wrFire = wrEn && notFull && ownWr && !stb.rewind;
    stb.rdFire = rdEn && notEmpty && ownRd && !stb.rewind;
    stb.qDrive = ownRd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      singleMode <= !xiN;
      wrTok      <= !flRtN;
      rdTok      <= !flRtN;
      wordCnt    <= '0;
      xoPulse    <= 1'b0;
      xoKind     <= 1'b0;
    end else begin
      if (stb.rewind) wordCnt <= CNT_W'(wrPtr);
      else wordCnt <= wordCnt + CNT_W'(stb.wrFire) - CNT_W'(stb.rdFire);
      xoPulse <= 1'b0;
      if (!singleMode) begin
        if (stb.wrFire && wrLast) begin
          wrTok   <= 1'b0;
          xoPulse <= 1'b1;
          xoKind  <= 1'b1;
        end else if (gainWr) begin
          wrTok <= 1'b1;
        end
        if (stb.rdFire && rdLast) begin
          rdTok   <= 1'b0;
          xoPulse <= 1'b1;
          xoKind  <= 1'b0;
        end else if (gainRd) begin
          rdTok <= 1'b1;
        end
      end
    end
  end

  assign fullN  = notFull;
  assign emptyN = notEmpty;
  assign xoHfN  = singleMode ? !(wordCnt > HALF_CNT) : !xoPulse;
  assign xoIsWr = xoKind;
endmodule

// File: rtl/xfifo_slice.sv
module xfifo_slice
  import xfifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] dIn,
  input  logic              flRtN,
  input  logic              xiN,
  input  logic              xiIsWr,
  output wire  [DATA_W-1:0] qOut,
  output logic              fullN,
  output logic              emptyN,
  output logic              xoHfN,
  output logic              xoIsWr
);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  ctrlStrobes_t      stb;
  logic              singleMode;
  logic [DATA_W-1:0] head;
  logic [ADDR_W-1:0] wrPtr;
  logic              wrLast, rdLast;

  xfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .flRtN(flRtN),
    .xiN(xiN), .xiIsWr(xiIsWr), .wrPtr(wrPtr), .wrLast(wrLast),
    .rdLast(rdLast), .stb(stb), .singleMode(singleMode), .fullN(fullN),
    .emptyN(emptyN), .xoHfN(xoHfN), .xoIsWr(xoIsWr)
  );

  xfifo_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .dIn(dIn), .head(head),
    .wrPtr(wrPtr), .wrLast(wrLast), .rdLast(rdLast)
  );

  assign qOut = stb.qDrive ? head : {DATA_W{1'bz}};
endmodule

// File: rtl/xfifo_slice_chk.sv
module xfifo_slice_chk (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic rdEn,
  input logic flRtN,
  input logic singleMode,
  input logic fullN,
  input logic emptyN,
  input logic xoHfN
);
  // R1
  reset_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!emptyN && fullN && xoHfN));

  // R4
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!fullN && !emptyN));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fullN && wrEn && !rdEn) |=> !fullN);

  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!emptyN && rdEn && !wrEn && flRtN) |=> !emptyN);

  // R5
  half_clear_when_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (singleMode && !emptyN) |-> xoHfN);

  // R8
  token_pulse_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!singleMode && !xoHfN && !$rose(rstN)) |-> $past(wrEn || rdEn));
endmodule

bind xfifo_slice xfifo_slice_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .flRtN(flRtN),
  .singleMode(singleMode), .fullN(fullN), .emptyN(emptyN), .xoHfN(xoHfN)
);

// File: tb/xfifo_slice_tb.sv
module xfifo_slice_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 9;
  localparam int DP = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  int nTests = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // single-mode instance
  logic sWr = 0, sRd = 0, sRt = 1;
  logic [DW-1:0] sDin = '0;
  wire  [DW-1:0] sQ;
  logic sFull, sEmpty, sHf, sKind;

  xfifo_slice #(.DATA_W(DW), .DEPTH(DP)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(sWr), .rdEn(sRd), .dIn(sDin),
    .flRtN(sRt), .xiN(1'b0), .xiIsWr(1'b0), .qOut(sQ), .fullN(sFull),
    .emptyN(sEmpty), .xoHfN(sHf), .xoIsWr(sKind)
  );

  // three-slice ring on a shared bus
  logic cWr = 0, cRd = 0;
  logic [DW-1:0] cDin = '0;
  wire  [DW-1:0] qBus;
  logic [2:0] cFull, cEmpty, cXo, cKind;

  for (genvar g = 0; g < 3; g++) begin : g_ring
    xfifo_slice #(.DATA_W(DW), .DEPTH(DP)) u_c (
      .clk(clk), .rstN(rstN), .wrEn(cWr), .rdEn(cRd), .dIn(cDin),
      .flRtN(g == 0 ? 1'b0 : 1'b1), .xiN(cXo[(g+2)%3]),
      .xiIsWr(cKind[(g+2)%3]), .qOut(qBus), .fullN(cFull[g]),
      .emptyN(cEmpty[g]), .xoHfN(cXo[g]), .xoIsWr(cKind[g])
    );
  end

  function automatic logic [DW-1:0] word(int i);
    return DW'((i * 37 + 5) & 9'h1FF);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp, string what);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; sWr = 0; sRd = 0; sRt = 1; cWr = 0; cRd = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic sWrite(logic [DW-1:0] d);
    sWr = 1; sDin = d; @(negedge clk); sWr = 0;
  endtask
  task automatic sRead();
    sRd = 1; @(negedge clk); sRd = 0;
  endtask
  task automatic cWrite(logic [DW-1:0] d);
    cWr = 1; cDin = d; @(negedge clk); cWr = 0;
  endtask
  task automatic cRead();
    cRd = 1; @(negedge clk); cRd = 0;
  endtask

  task automatic testReset();
    doReset();
    // R1: one cycle after release, sampled at the first negedge
    check("R1", 16'(sEmpty), 16'd0, "single emptyN");
    check("R1", 16'(sFull), 16'd1, "single fullN");
    check("R1", 16'(sHf), 16'd1, "single xoHfN");
    check("R1", 16'(cEmpty), 16'd0, "ring emptyN");
    check("R1", 16'(cXo), 16'h7, "ring xoHfN");
  endtask

  task automatic testSingleFill();
    doReset();
    sWrite(word(0)); sWrite(word(1));
    check("R5", 16'(sHf), 16'd1, "half flag at DEPTH/2");
    sWrite(word(2));
    check("R5", 16'(sHf), 16'd0, "half flag above DEPTH/2");
    check("R2", 16'(sHf), 16'd0, "single mode selected by low xiN");
    sWrite(word(3));
    check("R4", 16'(sFull), 16'd0, "full at DEPTH");
    sWrite(9'h0FF);
    check("R3", 16'(sFull), 16'd0, "write on full ignored");
    check("R10", 16'(sQ), 16'(word(0)), "single head");
    for (int i = 0; i < DP; i++) begin
      check("R3", 16'(sQ), 16'(word(i)), "single order");
      sRead();
    end
    check("R4", 16'(sEmpty), 16'd0, "empty after drain");
    sRead();
    check("R3", 16'(sEmpty), 16'd0, "read on empty ignored");
    sWrite(9'h033);
    check("R3", 16'(sQ), 16'h033, "word after ignored read");
    sRead();
    check("R3", 16'(sEmpty), 16'd0, "one write one read");
  endtask

  task automatic testRetransmit();
    doReset();
    sWrite(word(10)); sWrite(word(11)); sWrite(word(12));
    sRead(); sRead();
    check("R6", 16'(sQ), 16'(word(12)), "head before rewind");
    sRt = 0; @(negedge clk); sRt = 1;
    check("R6", 16'(sQ), 16'(word(10)), "head after rewind");
    check("R6", 16'(sEmpty), 16'd1, "not empty after rewind");
    check("R6", 16'(sHf), 16'd0, "count restored to three");
    for (int i = 0; i < 3; i++) begin
      check("R6", 16'(sQ), 16'(word(10 + i)), "replay order");
      sRead();
    end
    check("R6", 16'(sEmpty), 16'd0, "empty after replay");
  endtask

  task automatic testRing();
    doReset();
    for (int i = 0; i < 3 * DP; i++) begin
      cWrite(word(i));
      if (i == DP - 1) begin
        check("R4", 16'(cFull[0]), 16'd0, "slice 0 full");
        check("R7", 16'(cEmpty[1]), 16'd0, "slice 1 ignored writes");
        check("R8", 16'(cXo[0]), 16'd0, "write token pulse");
        check("R8", 16'(cKind[0]), 16'd1, "pulse kind write");
      end
      if (i == DP) begin
        check("R8", 16'(cXo[0]), 16'd1, "pulse one cycle");
        check("R9", 16'(cEmpty[1]), 16'd1, "slice 1 took write in pulse cycle");
        check("R2", 16'(cXo[1]), 16'd1, "ring mode, no half flag");
      end
    end
    check("R4", 16'(cFull), 16'd0, "all slices full");
    cWrite(9'h1AA);
    check("R3", 16'(cFull), 16'd0, "ring write on full ignored");
    check("R10", 16'(qBus), 16'(word(0)), "only slice 0 drives bus");
    for (int i = 0; i < 3 * DP; i++) begin
      check("R11", 16'(qBus), 16'(word(i)), "ring order on bus");
      cRead();
      if (i == DP - 1) begin
        check("R8", 16'(cXo[0]), 16'd0, "read token pulse");
        check("R8", 16'(cKind[0]), 16'd0, "pulse kind read");
      end
    end
    check("R11", 16'(cEmpty), 16'd0, "ring drained");
  endtask

  initial begin
    testReset();
    testSingleFill();
    testRetransmit();
    testRing();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule